// File: doc/BRIEF.md
# USB Device Line-State Monitor

This block sits next to a USB 2.0 device transceiver. It keeps watch on the two-bit line state and turns the lengths of idle and single-ended-zero periods into link events. It gets a microsecond timebase from the system clock. With that timebase it measures how long the bus has stayed in SE0 and how long it has stayed idle (J). A long enough SE0 is a bus reset. A long enough idle period puts the device into suspend. The bus reset is recognised both in normal operation and while suspended.

While suspended, the block can start remote wakeup. A wake request can come from an external pin or from a core-side bit, and the two are ORed. Wakeup is accepted only after the device has been suspended for a minimum dwell time, and only while the bus is idle. During the resume signalling window the operating mode is switched so that bit stuffing is off. The normal mode is restored when the window closes. The suspend indication goes out twice: as an active-high level and as the transceiver's active-low suspend pin. There is no power-on state tied to VBUS, so once reset is released the block is immediately in normal operation.

Top module: `usb_link_state_mon`

## Requirements
- R1: After reset: usb_reset = 0, suspend = 0, suspend_m_n = 1 and op_mode = 2'b00.
- R2: Line state 2'b00 (SE0) held for RESET_TICKS timebase ticks (one tick every TICK_CLKS clocks) produces exactly one single-cycle usb_reset pulse per SE0 episode.
- R3: SE0 shorter than RESET_TICKS-1 ticks, and any duration of J (2'b01), K (2'b10) or SE1 (2'b11), produces no usb_reset pulse.
- R4: Line state J held without change for SUSPEND_TICKS ticks in normal operation sets suspend = 1.
- R5: Any change of line state restarts the idle measurement, so two idle stretches that are each shorter than the threshold, separated by a brief K, do not cause suspend.
- R6: SE0 held for RESET_TICKS ticks while suspended gives one usb_reset pulse and clears suspend.
- R7: K or SE1 seen while suspended clears suspend and gives no usb_reset pulse.
- R8: A wake request made before the device has been suspended for WAKE_DWELL_TICKS ticks has no effect: suspend stays 1 and op_mode stays 2'b00.
- R9: After the dwell, either ext_wake_req or core_wake_req with the line in J starts resume: suspend = 0 and op_mode = 2'b10 (bit stuffing off) for RESUME_TICKS ticks, and then op_mode returns to 2'b00.
- R10: While suspended, a pending wake request does not start resume during SE0; a long SE0 gives a bus reset and op_mode never becomes 2'b10.
- R11: suspend_m_n is always the inverse of suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| ext_wake_req | input | 1 | Remote-wakeup request from an external pin (level) |
| core_wake_req | input | 1 | Remote-wakeup request from the device core (level) |
| usb_reset | output | 1 | One-cycle pulse when a bus reset is detected |
| suspend | output | 1 | High while the device is suspended |
| suspend_m_n | output | 1 | Active-low suspend control to the transceiver |
| op_mode | output | 2 | Transceiver operating mode: 00 normal, 10 bit stuffing disabled |

## Verification
Two functions can be ready in the same cycle: a held wake request that passes the dwell gate, and the bus-reset timer running in the suspend state. The bench holds a wake request high while SE0 is on the line after the dwell has passed. It judges the result by the reset pulse count going up by one and by op_mode never showing 2'b10. Constrained-random bursts of short SE0, K, SE1 and sub-threshold idle check that neither reset nor suspend happens on its own. Directed runs then cover each threshold and each suspend exit.

// File: rtl/usb_lsm_pkg.sv
package usb_lsm_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_NORMAL,
    ST_RESET,
    ST_SUSPEND,
    ST_RESUME
  } link_st_t;

  localparam logic [1:0] OPM_NORMAL  = 2'b00;
  localparam logic [1:0] OPM_NOSTUFF = 2'b10;
endpackage

// File: rtl/usb_lsm_tick.sv
module usb_lsm_tick #(
  parameter int TICK_CLKS = 60
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CLKS - 1);

  logic [TW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (div_q == LAST);
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  generate
    if (TICK_CLKS > 1) begin : g_gap
      // R2
      tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/usb_lsm_dur_cnt.sv
module usb_lsm_dur_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && (cnt != {W{1'b1}}))
      cnt <= cnt + 1'b1;
  end

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == {W{1'b1}} && !clr) |=> (cnt == {W{1'b1}}));
endmodule

// File: rtl/usb_lsm_fsm.sv
module usb_lsm_fsm
  import usb_lsm_pkg::*;
#(
  parameter int RESET_TICKS      = 3,
  parameter int SUSPEND_TICKS    = 3000,
  parameter int WAKE_DWELL_TICKS = 5000,
  parameter int RESUME_TICKS     = 2000,
  parameter int SW = 2,
  parameter int IW = 12,
  parameter int DW = 13,
  parameter int RW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  line_t         ls,
  input  logic          wake_req,
  input  logic [SW-1:0] se0_cnt,
  input  logic [IW-1:0] idle_cnt,
  input  logic [DW-1:0] dwell_cnt,
  input  logic [RW-1:0] res_cnt,
  output logic          in_normal,
  output logic          in_suspend,
  output logic          in_resume,
  output logic          usb_reset,
  output logic          suspend,
  output logic          suspend_m_n,
  output logic [1:0]    op_mode
);
  link_st_t st, nxt;

  logic se0_hit, idle_hit, dwell_ok, res_done;
  assign se0_hit  = (se0_cnt   >= SW'(RESET_TICKS));
  assign idle_hit = (idle_cnt  >= IW'(SUSPEND_TICKS));
  assign dwell_ok = (dwell_cnt >= DW'(WAKE_DWELL_TICKS));
  assign res_done = (res_cnt   >= RW'(RESUME_TICKS));

  always_comb begin
    nxt = st;
    unique case (st)
      ST_NORMAL:  if (se0_hit) nxt = ST_RESET;
                  else if (idle_hit) nxt = ST_SUSPEND;
      ST_RESET:   if (ls != LS_SE0) nxt = ST_NORMAL;
      ST_SUSPEND: if (se0_hit) nxt = ST_RESET;
                  else if (ls == LS_K || ls == LS_SE1) nxt = ST_NORMAL;
                  else if (ls == LS_J && wake_req && dwell_ok) nxt = ST_RESUME;
      ST_RESUME:  if (res_done) nxt = ST_NORMAL;
      default:    nxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_NORMAL;
      usb_reset   <= 1'b0;
      suspend     <= 1'b0;
      suspend_m_n <= 1'b1;
      op_mode     <= OPM_NORMAL;
    end else begin
      st          <= nxt;
      usb_reset   <= (nxt == ST_RESET) && (st != ST_RESET);
      suspend     <= (nxt == ST_SUSPEND);
      suspend_m_n <= (nxt != ST_SUSPEND);
      op_mode     <= (nxt == ST_RESUME) ? OPM_NOSTUFF : OPM_NORMAL;
    end
  end

  assign in_normal  = (st == ST_NORMAL);
  assign in_suspend = (st == ST_SUSPEND);
  assign in_resume  = (st == ST_RESUME);

  // R2
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    usb_reset |=> !usb_reset);
  // R11
  susp_pol_chk: assert property (@(posedge clk) disable iff (rst)
    suspend_m_n == !suspend);
  // R9
  opmode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (op_mode == OPM_NORMAL) || (op_mode == OPM_NOSTUFF));
  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(op_mode[1]) |-> ($past(dwell_cnt) >= DW'(WAKE_DWELL_TICKS)));
  // R10
  wake_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(op_mode[1]) |-> ($past(ls) == LS_J));
endmodule

// File: rtl/usb_link_state_mon.sv
module usb_link_state_mon
  import usb_lsm_pkg::*;
#(
  parameter int TICK_CLKS        = 60,
  parameter int RESET_TICKS      = 3,
  parameter int SUSPEND_TICKS    = 3000,
  parameter int WAKE_DWELL_TICKS = 5000,
  parameter int RESUME_TICKS     = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_state,
  input  logic       ext_wake_req,
  input  logic       core_wake_req,
  output logic       usb_reset,
  output logic       suspend,
  output logic       suspend_m_n,
  output logic [1:0] op_mode
);
  localparam int SW = $clog2(RESET_TICKS + 1);
  localparam int IW = $clog2(SUSPEND_TICKS + 1);
  localparam int DW = $clog2(WAKE_DWELL_TICKS + 1);
  localparam int RW = $clog2(RESUME_TICKS + 1);

  line_t ls_q, ls_prev;
  logic tick;
  logic in_normal, in_suspend, in_resume;
  logic [SW-1:0] se0_cnt;
  logic [IW-1:0] idle_cnt;
  logic [DW-1:0] dwell_cnt;
  logic [RW-1:0] res_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_q    <= LS_J;
      ls_prev <= LS_J;
    end else begin
      ls_q    <= line_t'(line_state);
      ls_prev <= ls_q;
    end
  end

  usb_lsm_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk(clk), .rst(rst), .tick(tick));

  usb_lsm_dur_cnt #(.W(SW)) u_se0 (
    .clk(clk), .rst(rst), .clr(ls_q != LS_SE0), .inc(tick), .cnt(se0_cnt));

  usb_lsm_dur_cnt #(.W(IW)) u_idle (
    .clk(clk), .rst(rst),
    .clr((ls_q != LS_J) || (ls_q != ls_prev) || !in_normal),
    .inc(tick), .cnt(idle_cnt));

  usb_lsm_dur_cnt #(.W(DW)) u_dwell (
    .clk(clk), .rst(rst), .clr(!in_suspend), .inc(tick), .cnt(dwell_cnt));

  usb_lsm_dur_cnt #(.W(RW)) u_res (
    .clk(clk), .rst(rst), .clr(!in_resume), .inc(tick), .cnt(res_cnt));

  usb_lsm_fsm #(
    .RESET_TICKS(RESET_TICKS), .SUSPEND_TICKS(SUSPEND_TICKS),
    .WAKE_DWELL_TICKS(WAKE_DWELL_TICKS), .RESUME_TICKS(RESUME_TICKS),
    .SW(SW), .IW(IW), .DW(DW), .RW(RW)
  ) u_fsm (
    .clk(clk), .rst(rst), .ls(ls_q),
    .wake_req(ext_wake_req | core_wake_req),
    .se0_cnt(se0_cnt), .idle_cnt(idle_cnt),
    .dwell_cnt(dwell_cnt), .res_cnt(res_cnt),
    .in_normal(in_normal), .in_suspend(in_suspend), .in_resume(in_resume),
    .usb_reset(usb_reset), .suspend(suspend),
    .suspend_m_n(suspend_m_n), .op_mode(op_mode));

  // R5
  idle_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (ls_q != ls_prev) |=> (idle_cnt == '0));
  // R7
  susp_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (suspend && (ls_q == LS_K || ls_q == LS_SE1)) |=> (!suspend && !usb_reset));
endmodule

// File: tb/usb_link_state_mon_test.sv
module usb_link_state_mon_test;
  localparam int TCK = 2, RST_T = 3, SUS_T = 20, DWELL_T = 30, RES_T = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] line_state = 2'b01;
  logic ext_wake_req = 1'b0, core_wake_req = 1'b0;
  logic usb_reset, suspend, suspend_m_n;
  logic [1:0] op_mode;

  int tests = 0, fails = 0;
  int pulses = 0, wake_runs = 0, wake_len = 0, cur_run = 0;
  bit susp_seen = 1'b0, pol_bad = 1'b0;

  always #2.5 clk = ~clk;

  usb_link_state_mon #(.TICK_CLKS(TCK), .RESET_TICKS(RST_T), .SUSPEND_TICKS(SUS_T),
    .WAKE_DWELL_TICKS(DWELL_T), .RESUME_TICKS(RES_T)) uut (
    .clk(clk), .rst(rst), .line_state(line_state), .ext_wake_req(ext_wake_req),
    .core_wake_req(core_wake_req), .usb_reset(usb_reset), .suspend(suspend),
    .suspend_m_n(suspend_m_n), .op_mode(op_mode));

  always @(negedge clk) if (!rst) begin
    if (usb_reset) pulses++;
    if (suspend) susp_seen = 1'b1;
    if (suspend_m_n == suspend) pol_bad = 1'b1;
    if (op_mode == 2'b10) cur_run++;
    else if (cur_run != 0) begin wake_runs++; wake_len = cur_run; cur_run = 0; end
  end

  // Bench model of the thresholds in clock cycles
  function automatic int cyc_for(input int ticks); return ticks * TCK; endfunction
  function automatic bit se0_must_reset(input int n); return n > cyc_for(RST_T) + 2; endfunction
  function automatic bit se0_never_reset(input int n); return n < cyc_for(RST_T - 1); endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic hold(input logic [1:0] ls, input int n);
    line_state = ls;
    repeat (n) @(negedge clk);
  endtask

  task automatic go_suspend();
    hold(2'b10, 2);
    hold(2'b01, cyc_for(SUS_T) + 10);
  endtask

  initial begin
    int p0, w0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk(usb_reset == 0 && suspend == 0 && suspend_m_n == 1 && op_mode == 2'b00,
        "R1", {usb_reset, suspend, suspend_m_n, op_mode}, 5'b00100);
    rst = 1'b0;
    @(negedge clk);

    // Random bursts, all below the thresholds (R3, R5)
    for (int i = 0; i < 80; i++) begin
      int jl = $urandom_range(1, cyc_for(SUS_T) - 12);
      int nl = $urandom_range(1, cyc_for(RST_T - 1) - 1);
      logic [1:0] other = 2'($urandom_range(0, 3));
      if (other == 2'b01) other = 2'b11;
      hold(2'b01, jl);
      if (other == 2'b00) chk(se0_never_reset(nl), "R3", nl, 0);
      hold(other, nl);
    end
    hold(2'b01, 3);
    chk(pulses == 0, "R3", pulses, 0);
    chk(!susp_seen, "R5", susp_seen, 0);

    // R5: two idle stretches split by a brief K
    hold(2'b01, cyc_for(SUS_T) - 10);
    hold(2'b10, 1);
    hold(2'b01, cyc_for(SUS_T) - 10);
    chk(!susp_seen, "R5", susp_seen, 0);

    // R2: long SE0, one pulse
    chk(se0_must_reset(30), "R2", 30, 1);
    hold(2'b00, 30);
    hold(2'b01, 3);
    chk(pulses == 1, "R2", pulses, 1);

    // R4: long idle enters suspend
    go_suspend();
    chk(suspend == 1 && suspend_m_n == 0, "R4", suspend, 1);

    // R8: early request ignored
    ext_wake_req = 1'b1;
    repeat (cyc_for(DWELL_T) / 2) @(negedge clk);
    ext_wake_req = 1'b0;
    @(negedge clk);
    chk(suspend == 1 && op_mode == 2'b00, "R8", op_mode, 0);
    chk(wake_runs == 0 && cur_run == 0, "R8", wake_runs, 0);

    // R9: external request after dwell
    repeat (cyc_for(DWELL_T)) @(negedge clk);
    ext_wake_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(op_mode == 2'b10 && suspend == 0, "R9", op_mode, 2);
    ext_wake_req = 1'b0;
    repeat (cyc_for(RES_T) + 6) @(negedge clk);
    chk(op_mode == 2'b00 && suspend == 0, "R9", op_mode, 0);
    chk(wake_runs == 1 && wake_len >= cyc_for(RES_T) - 3 && wake_len <= cyc_for(RES_T) + 3,
        "R9", wake_len, cyc_for(RES_T));

    // R9: core request path
    go_suspend();
    repeat (cyc_for(DWELL_T) + 4) @(negedge clk);
    core_wake_req = 1'b1;
    repeat (4) @(negedge clk);
    core_wake_req = 1'b0;
    chk(op_mode == 2'b10, "R9", op_mode, 2);
    repeat (cyc_for(RES_T) + 6) @(negedge clk);
    chk(wake_runs == 2 && op_mode == 2'b00, "R9", wake_runs, 2);

    // R6: SE0 from suspend gives reset
    go_suspend();
    p0 = pulses;
    hold(2'b00, 30);
    chk(pulses == p0 + 1 && suspend == 0, "R6", pulses - p0, 1);
    hold(2'b01, 3);

    // R7: K and SE1 leave suspend without reset
    go_suspend();
    p0 = pulses;
    hold(2'b10, 4);
    chk(suspend == 0 && pulses == p0, "R7", suspend, 0);
    go_suspend();
    hold(2'b11, 4);
    chk(suspend == 0 && pulses == p0, "R7", suspend, 0);

    // R10: pending request during SE0 in suspend, reset wins
    go_suspend();
    repeat (cyc_for(DWELL_T) + 4) @(negedge clk);
    p0 = pulses; w0 = wake_runs;
    line_state = 2'b00;
    repeat (2) @(negedge clk);
    ext_wake_req = 1'b1;
    repeat (30) @(negedge clk);
    line_state = 2'b01; ext_wake_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(pulses == p0 + 1, "R10", pulses - p0, 1);
    chk(wake_runs == w0 && cur_run == 0, "R10", wake_runs - w0, 0);

    chk(!pol_bad, "R11", pol_bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule